// File: doc/BRIEF.md
# Lock-Guarded Atomic Memory Operation Engine

This block performs one atomic read-modify-write on a word of shared memory. Atomicity comes from a software lock that it shares with a peer processor. The lock lives in two words of a shared region that starts at `REGION_BASE`. The word at offset 0 holds the peer's lock requests. The word at offset 1 shows that this engine holds the lock.

A request carries an operation code, a target offset inside the region, an operand and a lock mask. The engine first reads the peer word over and over until its AND with the mask is zero. It then writes the mask into its own lock word and reads the target. Next it writes back the new value when the operation calls for one, releases the lock by writing zero to its own lock word, and pulses `done_o` with a 16-bit result. All traffic goes through one single-port memory master that uses a valid/ready handshake. Only one request is in flight at a time.

Top module: `atomic_lock_engine`

## Requirements
- R1: While reset is held, and in the idle state after it, `req_ready_o` is 1 and both `mem_valid_o` and `done_o` are 0. An asynchronous reset in the middle of an operation returns the engine to this state.
- R2: The engine reads address `REGION_BASE+0` and ANDs the data with the request mask. It repeats the read while that AND is nonzero, and it makes no other memory access in that time.
- R3: Once the AND is zero, the engine writes the mask to `REGION_BASE+1`. Only after that write does it access the target, so the own-lock word equals the mask whenever the target is accessed.
- R4: Op code 0 is add, 1 is and, 2 is or. For each, new = operand combined with the old word (add wraps modulo 2^16). The new value is written to the target and returned as the result.
- R5: Op code 3 is exchange. The operand is written to the target and the old word is returned.
- R6: Op code 4 is write-if-zero. The operand is written only when the old word is zero, and the old word is returned in both cases.
- R7: Op codes 5, 6 and 7 make no write to the target and return the old word.
- R8: The last memory access of every operation writes zero to `REGION_BASE+1`. In the following cycle `done_o` pulses high for exactly one cycle, with `result_o` valid.
- R9: A memory request keeps address, write enable and write data stable until `mem_ready_i`. `req_ready_o` is 0 from acceptance until after `done_o`, and a request offered in that time is ignored.
- R10: The target address is `REGION_BASE + offset`, modulo 2^ADDR_W, and the target is read exactly once per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Engine idle, request accepted when valid |
| req_op_i | input | 3 | Operation code |
| req_offset_i | input | ADDR_W | Target offset within the region |
| req_operand_i | input | DATA_W | Operand value |
| req_mask_i | input | DATA_W | Lock mask |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request; read data valid this cycle |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid with `mem_ready_i` |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DATA_W | Operation result |

## Verification
A wrong sequencer state shows up on the bus on the first request that follows it. Examples are a target access before the claim write, a poll that stops while the peer still holds a masked bit, or a missing release. The bench therefore watches every accepted memory transfer and checks each one against the lock protocol as it happens. A bad ALU selection or write-enable decision only shows at `done_o` and in the target word after the operation, so both are compared for every operation code, including write-if-zero on a nonzero word, the undefined codes, and add with wrap. Hold stability, the single done pulse and the claim value are checked on every cycle by properties.

// File: rtl/atom_pkg.sv
package atom_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_ADD  = 3'd0;
  localparam logic [OP_W-1:0] OP_AND  = 3'd1;
  localparam logic [OP_W-1:0] OP_OR   = 3'd2;
  localparam logic [OP_W-1:0] OP_XCHG = 3'd3;
  localparam logic [OP_W-1:0] OP_WRZ  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_CLAIM,
    ST_TRD,
    ST_EXEC,
    ST_TWR,
    ST_REL,
    ST_DONE
  } atom_st_e;
endpackage

// File: rtl/atom_alu.sv
module atom_alu
  import atom_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] old_i,
  output logic [DATA_W-1:0] new_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] result_o
);
  always_comb begin
    new_o    = old_i;
    wr_en_o  = 1'b0;
    result_o = old_i;
    unique case (op_i)
      OP_ADD:  begin new_o = old_i + operand_i; wr_en_o = 1'b1; result_o = new_o; end
      OP_AND:  begin new_o = old_i & operand_i; wr_en_o = 1'b1; result_o = new_o; end
      OP_OR:   begin new_o = old_i | operand_i; wr_en_o = 1'b1; result_o = new_o; end
      OP_XCHG: begin new_o = operand_i;         wr_en_o = 1'b1; end
      OP_WRZ:  begin new_o = operand_i;         wr_en_o = (old_i == '0); end
      default: ;
    endcase
  end
endmodule

// File: rtl/atom_fsm.sv
module atom_fsm
  import atom_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_fire_i,
  input  logic     mem_ready_i,
  input  logic     lock_free_i,
  input  logic     do_write_i,
  output atom_st_e state_o
);
  atom_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_fire_i) st_d = ST_POLL;
      ST_POLL:  if (mem_ready_i && lock_free_i) st_d = ST_CLAIM;
      ST_CLAIM: if (mem_ready_i) st_d = ST_TRD;
      ST_TRD:   if (mem_ready_i) st_d = ST_EXEC;
      ST_EXEC:  st_d = do_write_i ? ST_TWR : ST_REL;
      ST_TWR:   if (mem_ready_i) st_d = ST_REL;
      ST_REL:   if (mem_ready_i) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/atom_bus.sv
module atom_bus
  import atom_pkg::*;
#(
  parameter int                   ADDR_W      = 16,
  parameter int                   DATA_W      = 16,
  parameter logic [ADDR_W-1:0]    REGION_BASE = '0
) (
  input  atom_st_e            state_i,
  input  logic [ADDR_W-1:0]   offset_i,
  input  logic [DATA_W-1:0]   mask_i,
  input  logic [DATA_W-1:0]   new_i,
  output logic                valid_o,
  output logic                we_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   wdata_o
);
  localparam logic [ADDR_W-1:0] PEER_ADDR = REGION_BASE;
  localparam logic [ADDR_W-1:0] OWN_ADDR  = REGION_BASE + ADDR_W'(1);

  logic [ADDR_W-1:0] tgt_addr;
  assign tgt_addr = REGION_BASE + offset_i;

  always_comb begin
    valid_o = 1'b1;
    we_o    = 1'b0;
    addr_o  = PEER_ADDR;
    wdata_o = '0;
    unique case (state_i)
      ST_POLL:  ;
      ST_CLAIM: begin we_o = 1'b1; addr_o = OWN_ADDR; wdata_o = mask_i; end
      ST_TRD:   addr_o = tgt_addr;
      ST_TWR:   begin we_o = 1'b1; addr_o = tgt_addr; wdata_o = new_i; end
      ST_REL:   begin we_o = 1'b1; addr_o = OWN_ADDR; end
      default:  valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/atomic_lock_engine.sv
module atomic_lock_engine
  import atom_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 16,
  parameter logic [ADDR_W-1:0] REGION_BASE = 16'h0040
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [OP_W-1:0]   req_op_i,
  input  logic [ADDR_W-1:0] req_offset_i,
  input  logic [DATA_W-1:0] req_operand_i,
  input  logic [DATA_W-1:0] req_mask_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  atom_st_e          state;
  logic              req_fire;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] off_q;
  logic [DATA_W-1:0] opnd_q, mask_q, old_q, res_q;
  logic [DATA_W-1:0] alu_new, alu_res;
  logic              alu_wr, lock_free;

  assign req_ready_o = (state == ST_IDLE);
  assign req_fire    = req_valid_i && req_ready_o;
  assign lock_free   = ((mem_rdata_i & mask_q) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      off_q  <= '0;
      opnd_q <= '0;
      mask_q <= '0;
      old_q  <= '0;
      res_q  <= '0;
    end else begin
      if (req_fire) begin
        op_q   <= req_op_i;
        off_q  <= req_offset_i;
        opnd_q <= req_operand_i;
        mask_q <= req_mask_i;
      end
      if (state == ST_TRD && mem_ready_i) old_q <= mem_rdata_i;
      if (state == ST_EXEC) res_q <= alu_res;
    end
  end

  atom_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_fire_i  (req_fire),
    .mem_ready_i (mem_ready_i),
    .lock_free_i (lock_free),
    .do_write_i  (alu_wr),
    .state_o     (state)
  );

  atom_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i      (op_q),
    .operand_i (opnd_q),
    .old_i     (old_q),
    .new_o     (alu_new),
    .wr_en_o   (alu_wr),
    .result_o  (alu_res)
  );

  atom_bus #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .REGION_BASE (REGION_BASE)
  ) u_bus (
    .state_i  (state),
    .offset_i (off_q),
    .mask_i   (mask_q),
    .new_i    (alu_new),
    .valid_o  (mem_valid_o),
    .we_o     (mem_we_o),
    .addr_o   (mem_addr_o),
    .wdata_o  (mem_wdata_o)
  );

  assign done_o   = (state == ST_DONE);
  assign result_o = res_q;
endmodule

// File: rtl/atom_checker.sv
module atom_checker #(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 16,
  parameter logic [ADDR_W-1:0] REGION_BASE = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [DATA_W-1:0] req_mask_i,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              done_o
);
  localparam logic [ADDR_W-1:0] OWN_ADDR = REGION_BASE + ADDR_W'(1);

  logic [DATA_W-1:0] mask_cap;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_cap <= '0;
    else if (req_valid_i && req_ready_o) mask_cap <= req_mask_i;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_valid_o && !done_o));

  assert_poll_is_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_addr_o == REGION_BASE) |-> !mem_we_o);

  assert_claim_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_we_o && mem_addr_o == OWN_ADDR) |->
      (mem_wdata_o == '0 || mem_wdata_o == mask_cap));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_idle_after_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o);
endmodule

bind atomic_lock_engine atom_checker #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .REGION_BASE (REGION_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_mask_i  (req_mask_i),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .done_o      (done_o)
);

// File: tb/atomic_lock_engine_test.sv
`timescale 1ns/1ps
module atomic_lock_engine_test;
  localparam logic [15:0] BASE = 16'h0040;
  localparam logic [15:0] OWN  = BASE + 16'd1;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  off;
    logic [15:0] init;
    logic [15:0] opnd;
    logic [15:0] mask;
    logic [15:0] peer;
    logic [15:0] exp_res;
    logic [15:0] exp_mem;
    logic        exp_wr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [0:NV-1] = '{
    '{3'd0, 8'h05, 16'h1234, 16'h0101, 16'h0003, 16'h0000, 16'h1335, 16'h1335, 1'b1},
    '{3'd1, 8'h06, 16'hF0F0, 16'h3C3C, 16'h00FF, 16'h0000, 16'h3030, 16'h3030, 1'b1},
    '{3'd2, 8'h07, 16'h0F00, 16'h00F0, 16'h8000, 16'h0000, 16'h0FF0, 16'h0FF0, 1'b1},
    '{3'd3, 8'h08, 16'hAAAA, 16'h5555, 16'h0001, 16'h0000, 16'hAAAA, 16'h5555, 1'b1},
    '{3'd4, 8'h09, 16'h0000, 16'h7777, 16'h0002, 16'h0000, 16'h0000, 16'h7777, 1'b1},
    '{3'd4, 8'h0A, 16'h0001, 16'h7777, 16'h0002, 16'h0000, 16'h0001, 16'h0001, 1'b0},
    '{3'd0, 8'h0B, 16'hFFFF, 16'h0002, 16'h0004, 16'h0000, 16'h0001, 16'h0001, 1'b1},
    '{3'd5, 8'h0C, 16'h4242, 16'h9999, 16'h0001, 16'h0000, 16'h4242, 16'h4242, 1'b0},
    '{3'd7, 8'h0D, 16'h0000, 16'h1111, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 1'b0},
    '{3'd0, 8'h0E, 16'h0001, 16'h0001, 16'h000F, 16'h00F0, 16'h0002, 16'h0002, 1'b1},
    '{3'd6, 8'h0F, 16'h8000, 16'hFFFF, 16'h0010, 16'h0000, 16'h8000, 16'h8000, 1'b0},
    '{3'd1, 8'h10, 16'hFFFF, 16'h0000, 16'h0008, 16'h0000, 16'h0000, 16'h0000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [15:0] req_off = '0, req_opnd = '0, req_mask = '0;
  logic        mem_valid, mem_ready = 1'b0, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        done;
  logic [15:0] result;

  logic [15:0] mem [0:255];
  int total = 0, bad = 0, cyc = 0;
  logic [15:0] cur_tgt, cur_mask;
  int tgt_rd, tgt_wr, polls, foreign;
  logic claim_bad, after_rel, released;

  always #4 clk = ~clk;

  atomic_lock_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_offset_i(req_off),
    .req_operand_i(req_opnd), .req_mask_i(req_mask),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .done_o(done), .result_o(result)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  // memory stalls one cycle in four
  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= ((cyc % 4) != 3);
  end

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_addr == cur_tgt) begin
        if (mem[OWN[7:0]] != cur_mask) claim_bad = 1'b1;
        if (released) after_rel = 1'b1;
        if (mem_we) tgt_wr++; else tgt_rd++;
      end else if (mem_addr == BASE && !mem_we) begin
        polls++;
      end else if (mem_addr == OWN && mem_we) begin
        if (mem_wdata == 16'h0) released = 1'b1;
        else if (tgt_rd != 0 || released) after_rel = 1'b1;
      end else begin
        foreign++;
      end
      if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_mon(input logic [15:0] tgt, input logic [15:0] msk);
    cur_tgt = tgt; cur_mask = msk;
    tgt_rd = 0; tgt_wr = 0; polls = 0; foreign = 0;
    claim_bad = 0; after_rel = 0; released = 0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] off,
                       input logic [15:0] opnd, input logic [15:0] msk);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_off = off; req_opnd = opnd; req_mask = msk;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output logic [15:0] res, output bit seen);
    seen = 0; res = '0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin seen = 1; res = result; break; end
      @(negedge clk);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0, 3'd1, 3'd2: return "R4";
      3'd3:             return "R5";
      3'd4:             return "R6";
      default:          return "R7";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] res;
    bit seen;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    clr_mon(16'hFFFF, 16'h0);
    #1;
    // R1: values during reset
    chk(req_ready == 1'b1 && mem_valid == 1'b0 && done == 1'b0, "R1 in reset",
        {13'h0, req_ready, mem_valid, done}, 16'h4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_valid == 1'b0 && done == 1'b0, "R1 idle",
        {13'h0, req_ready, mem_valid, done}, 16'h4);

    // table walk
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [15:0] tgt;
      t = VECS[v];
      tgt = BASE + {8'h0, t.off};
      mem[tgt[7:0]] = t.init;
      mem[BASE[7:0]] = t.peer;
      mem[OWN[7:0]] = 16'h0;
      clr_mon(tgt, t.mask);
      issue(t.op, {8'h0, t.off}, t.opnd, t.mask);
      wait_done(res, seen);
      chk(seen && res == t.exp_res, op_tag(t.op), res, t.exp_res);
      chk(mem[tgt[7:0]] == t.exp_mem, op_tag(t.op), mem[tgt[7:0]], t.exp_mem);
      chk(tgt_wr == int'(t.exp_wr), op_tag(t.op), 16'(tgt_wr), {15'h0, t.exp_wr});
      chk(tgt_rd == 1 && foreign == 0, "R10 target", 16'(tgt_rd), 16'h1);
      chk(!claim_bad, "R3 claim before target", {15'h0, claim_bad}, 16'h0);
      chk(released && !after_rel && mem[OWN[7:0]] == 16'h0, "R8 release",
          mem[OWN[7:0]], 16'h0);
      chk(polls == 1, "R2 single poll", 16'(polls), 16'h1);
      @(negedge clk);
      chk(!done && req_ready, "R8 done one cycle", {14'h0, done, req_ready}, 16'h1);
    end

    // R2 / R9: peer holds the lock, second request offered while busy
    mem[8'h60] = 16'h0005;
    mem[8'h61] = 16'h0009;
    mem[BASE[7:0]] = 16'h0300;
    mem[OWN[7:0]] = 16'h0;
    clr_mon(16'h0060, 16'h0100);
    issue(3'd0, 16'h0020, 16'h0003, 16'h0100);
    repeat (10) @(negedge clk);
    chk(req_ready == 1'b0, "R9 busy not ready", {15'h0, req_ready}, 16'h0);
    req_valid = 1'b1; req_op = 3'd3; req_off = 16'h0021; req_opnd = 16'hDEAD; req_mask = 16'h0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(tgt_rd == 0 && tgt_wr == 0 && !done, "R2 spin no target access",
        16'(tgt_rd + tgt_wr), 16'h0);
    chk(polls >= 5 && foreign == 0, "R2 spin polls", 16'(polls), 16'h5);
    mem[BASE[7:0]] = 16'h0200;  // masked bit dropped
    wait_done(res, seen);
    chk(seen && res == 16'h0008, "R2 result after spin", res, 16'h0008);
    chk(!claim_bad, "R3 claim after spin", {15'h0, claim_bad}, 16'h0);
    chk(mem[8'h61] == 16'h0009, "R9 busy request ignored", mem[8'h61], 16'h0009);
    begin
      int extra = 0;
      @(negedge clk);
      for (int i = 0; i < 20; i++) begin
        if (done) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R9 no second operation", 16'(extra), 16'h0);
    end

    // R1: reset while spinning
    mem[BASE[7:0]] = 16'h0001;
    clr_mon(16'h0062, 16'h0001);
    issue(3'd2, 16'h0022, 16'h00FF, 16'h0001);
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(req_ready && !mem_valid && !done, "R1 reset mid-operation",
        {13'h0, req_ready, mem_valid, done}, 16'h4);
    @(negedge clk);
    rst_n = 1'b1;
    mem[BASE[7:0]] = 16'h0;
    repeat (4) @(negedge clk);
    chk(req_ready && !mem_valid, "R1 idle after reset", {14'h0, req_ready, mem_valid}, 16'h2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule